// File: doc/BRIEF.md
# Extended-Precision Narrowing Store Converter

This block converts an 80-bit extended-precision value into a 32-bit single-precision or 64-bit double-precision word. The value arrives as a sign bit, a 15-bit biased exponent and a 64-bit significand whose integer bit is explicit. It is used on the store path of a floating-point unit. Each cycle one value is presented together with a destination-format select, a 2-bit rounding-control field and an overflow mask bit. One clock later the block returns the narrowed word, a store-enable, four exception flags and a round-direction bit.

Finite values are rounded to the destination precision and their exponent is re-biased. When the value is tiny, the result is denormalized and rounded at the destination's fixed least-significant weight. Zeros, infinities and NaNs are not rounded: their fraction is cut down to the destination width. A signalling NaN is made quiet. Encodings the extended format does not support produce the default quiet NaN. An overflow that is not masked withholds the store.

Top module: `ext_store_narrow`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge.
- R2: The outputs for an input accepted with `in_valid` appear one clock later with `out_valid` high. With `dst_dbl`=0 the single-precision word is placed in `out_word[31:0]` and bits 63:32 are 0. With `dst_dbl`=1 the whole 64-bit word is used. Each word is laid out as sign, exponent, fraction, from the most significant bit down.
- R3: When the rounded finite value exceeds the destination's largest finite number, `flag_ovf` is 1. If `ovf_mask` is 0 in that case, `store_en` is 0 and `out_word` is 0.
- R4: For a masked overflow, the result is an infinity of the input's sign under round-to-nearest, or when the rounding direction points away from zero for that sign. Otherwise the result is the largest finite value of that sign. `flag_prec` is 1 in both cases.
- R5: `rnd_mode` selects how the significand is rounded: 00 to nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. A carry out of the significand increments the exponent.
- R6: A normal input with unbiased exponent E gives the destination exponent field E+127 (single) or E+1023 (double), when that field lies in the normal range.
- R7: A nonzero finite input below the destination's smallest normal magnitude sets `flag_unf`. This is tested before rounding, and applies also when rounding lifts the result to the smallest normal. Extended denormals are included. The result is denormalized and rounded per R5.
- R8: `flag_prec` is 1 when the stored finite result differs from the input. `rnd_up` is 1 only when the magnitude was increased, and is 0 whenever `flag_prec` is 0.
- R9: Signed zeros and signed infinities convert to the same class with the same sign, and raise no flag.
- R10: A NaN (exponent all ones, integer bit 1, nonzero fraction) keeps its sign. Its result fraction is the top fraction bits of the input's 63-bit fraction. Input fraction bit 62 is the quiet bit. If that bit is 0, the result's top fraction bit is forced to 1 and `flag_inv` is 1.
- R11: An unsupported encoding raises `flag_inv` and produces the default NaN: sign 1, exponent all ones, fraction MSB 1, other fraction bits 0. Unsupported encodings are a nonzero, non-maximal exponent with integer bit 0, or a maximal exponent with integer bit 0.
- R12: `store_en` is 1 for every accepted input except the unmasked overflow of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An input value is presented this cycle |
| in_sign | input | 1 | Sign of the extended value |
| in_exp | input | 15 | Biased exponent (bias 16383) |
| in_sig | input | 64 | Significand, bit 63 is the explicit integer bit |
| dst_dbl | input | 1 | 1 selects double precision, 0 single precision |
| rnd_mode | input | 2 | Rounding control, encoding per R5 |
| ovf_mask | input | 1 | 1 masks overflow, 0 suppresses the store on overflow |
| out_valid | output | 1 | Result outputs are valid |
| out_word | output | 64 | Narrowed word |
| store_en | output | 1 | The word should be written |
| flag_inv | output | 1 | Invalid operation |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow (tiny before rounding) |
| flag_prec | output | 1 | Inexact result |
| rnd_up | output | 1 | Magnitude was rounded up |

## Verification
The bench builds the block with its default parameters: a 15-bit exponent with a 64-bit significand, narrowed to 8/23 and 11/52 exponent/fraction layouts. These reach both destination widths with a single elaboration. They also make both overflow boundaries and the tiny region reachable from ordinary exponent offsets around each bias. Directed vectors cover ties, carries into the exponent, rounding into the smallest normal and every special class. Random vectors near both exponent limits then mix all rounding modes and mask settings.

// File: rtl/ext_store_pkg.sv
package ext_store_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_FINITE = 3'd1,
    CLS_INF    = 3'd2,
    CLS_QNAN   = 3'd3,
    CLS_SNAN   = 3'd4,
    CLS_UNSUP  = 3'd5
  } val_class_e;

  localparam logic [1:0] RC_NEAR = 2'b00;
  localparam logic [1:0] RC_DOWN = 2'b01;
  localparam logic [1:0] RC_UP   = 2'b10;
  localparam logic [1:0] RC_ZERO = 2'b11;

endpackage

// File: rtl/ext_classify.sv
module ext_classify
  import ext_store_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  parameter int UNB_W = EXP_W + 3
) (
  input  logic [EXP_W-1:0]        exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output val_class_e              cls_o,
  output logic signed [UNB_W-1:0] e_unb_o
);

  localparam int BIAS = 2**(EXP_W-1) - 1;
  localparam logic signed [UNB_W-1:0] BIAS_S = UNB_W'(BIAS);
  localparam logic signed [UNB_W-1:0] DEN_E  = UNB_W'(1 - BIAS);

  logic exp_zero, exp_max, int_bit, frac_nz, quiet_bit;
  logic signed [UNB_W-1:0] exp_ext;

  always_comb begin
    exp_zero  = (exp_i == '0);
    exp_max   = (exp_i == '1);
    int_bit   = sig_i[SIG_W-1];
    quiet_bit = sig_i[SIG_W-2];
    frac_nz   = (sig_i[SIG_W-2:0] != '0);
    exp_ext   = signed'({{(UNB_W-EXP_W){1'b0}}, exp_i});
    e_unb_o   = exp_zero ? DEN_E : (exp_ext - BIAS_S);

    if (exp_max) begin
      if (!int_bit)      cls_o = CLS_UNSUP;
      else if (!frac_nz) cls_o = CLS_INF;
      else if (quiet_bit) cls_o = CLS_QNAN;
      else               cls_o = CLS_SNAN;
    end else if (exp_zero) begin
      cls_o = (sig_i == '0) ? CLS_ZERO : CLS_FINITE;
    end else begin
      cls_o = int_bit ? CLS_FINITE : CLS_UNSUP;
    end
  end

endmodule

// File: rtl/narrow_fmt.sv
module narrow_fmt
  import ext_store_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int SIG_W  = 64,
  parameter int UNB_W  = 18,
  parameter int OUT_W  = 64
) (
  input  logic                    sign_i,
  input  val_class_e              cls_i,
  input  logic signed [UNB_W-1:0] e_unb_i,
  input  logic [SIG_W-1:0]        sig_i,
  input  logic [1:0]              rc_i,
  input  logic                    omask_i,
  output logic [OUT_W-1:0]        word_o,
  output logic                    store_o,
  output logic                    inv_o,
  output logic                    ovf_o,
  output logic                    unf_o,
  output logic                    prec_o,
  output logic                    up_o
);

  localparam int P    = FRAC_W + 1;
  localparam int BIAS = 2**(EXP_W-1) - 1;
  localparam int SH_W = $clog2(SIG_W + 1);
  localparam logic signed [UNB_W-1:0] BIAS_S = UNB_W'(BIAS);
  localparam logic signed [UNB_W-1:0] EMIN_S = UNB_W'(1 - BIAS);
  localparam logic signed [UNB_W-1:0] MAXE_S = UNB_W'(2**EXP_W - 1);
  localparam logic signed [UNB_W-1:0] SIGW_S = UNB_W'(SIG_W);
  localparam logic signed [UNB_W-1:0] ONE_S  = UNB_W'(1);
  localparam logic signed [UNB_W-1:0] ZERO_S = '0;
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [FRAC_W-1:0] QBIT     = {1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [OUT_W-1:0] pack(input logic s, input logic [EXP_W-1:0] e,
                                            input logic [FRAC_W-1:0] f);
    return OUT_W'({s, e, f});
  endfunction

  logic signed [UNB_W-1:0] deficit, biased;
  logic [SH_W-1:0]   sh;
  logic              tiny, lost, guard, sticky, inexact, inc, carry, ovf_hit, to_inf;
  logic [SIG_W-1:0]  mshift;
  logic [P-1:0]      kept;
  logic [P:0]        sum;
  logic [EXP_W-1:0]  exp_fld;
  logic [FRAC_W-1:0] nan_frac;
  logic [OUT_W-1:0]  fin_word, ovf_word;

  // Finite path: denormalizing shift, guard/sticky extraction, rounding.
  always_comb begin
    deficit = EMIN_S - e_unb_i;
    tiny    = (deficit > ZERO_S);
    if (!tiny)                  sh = '0;
    else if (deficit >= SIGW_S) sh = SH_W'(SIG_W);
    else                        sh = deficit[SH_W-1:0];

    mshift  = sig_i >> sh;
    lost    = |(sig_i & ~({SIG_W{1'b1}} << sh));
    kept    = mshift[SIG_W-1 -: P];
    guard   = mshift[SIG_W-1-P];
    sticky  = (|mshift[SIG_W-2-P:0]) | lost;
    inexact = guard | sticky;

    case (rc_i)
      RC_NEAR: inc = guard & (sticky | kept[0]);
      RC_DOWN: inc = inexact & sign_i;
      RC_UP:   inc = inexact & ~sign_i;
      default: inc = 1'b0;
    endcase

    sum     = {1'b0, kept} + (P+1)'(inc);
    carry   = sum[P];
    biased  = e_unb_i + BIAS_S + (carry ? ONE_S : ZERO_S);
    ovf_hit = !tiny && (biased >= MAXE_S);
    exp_fld = tiny ? EXP_W'(sum[P-1]) : biased[EXP_W-1:0];
    fin_word = pack(sign_i, exp_fld, sum[FRAC_W-1:0]);

    to_inf  = (rc_i == RC_NEAR) || (rc_i == RC_UP && !sign_i) || (rc_i == RC_DOWN && sign_i);
    ovf_word = to_inf ? pack(sign_i, EXP_ONES, '0)
                      : pack(sign_i, EXP_ONES - EXP_W'(1), '1);
  end

  // Class-driven selection of the final word and flags.
  always_comb begin
    nan_frac = sig_i[SIG_W-2 -: FRAC_W];
    word_o   = '0;
    store_o  = 1'b1;
    inv_o    = 1'b0;
    ovf_o    = 1'b0;
    unf_o    = 1'b0;
    prec_o   = 1'b0;
    up_o     = 1'b0;
    case (cls_i)
      CLS_ZERO: word_o = pack(sign_i, '0, '0);
      CLS_INF:  word_o = pack(sign_i, EXP_ONES, '0);
      CLS_QNAN: word_o = pack(sign_i, EXP_ONES, nan_frac);
      CLS_SNAN: begin
        word_o = pack(sign_i, EXP_ONES, nan_frac | QBIT);
        inv_o  = 1'b1;
      end
      CLS_FINITE: begin
        ovf_o   = ovf_hit;
        unf_o   = tiny;
        prec_o  = inexact | ovf_hit;
        up_o    = ovf_hit ? to_inf : inc;
        store_o = !(ovf_hit && !omask_i);
        word_o  = !store_o ? '0 : (ovf_hit ? ovf_word : fin_word);
      end
      default: begin
        word_o = pack(1'b1, EXP_ONES, QBIT);
        inv_o  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ext_store_narrow.sv
module ext_store_narrow
  import ext_store_pkg::*;
#(
  parameter int EXT_EXP_W  = 15,
  parameter int EXT_SIG_W  = 64,
  parameter int SGL_EXP_W  = 8,
  parameter int SGL_FRAC_W = 23,
  parameter int DBL_EXP_W  = 11,
  parameter int DBL_FRAC_W = 52
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic [EXT_EXP_W-1:0]    in_exp,
  input  logic [EXT_SIG_W-1:0]    in_sig,
  input  logic                    dst_dbl,
  input  logic [1:0]              rnd_mode,
  input  logic                    ovf_mask,
  output logic                    out_valid,
  output logic [DBL_EXP_W+DBL_FRAC_W:0] out_word,
  output logic                    store_en,
  output logic                    flag_inv,
  output logic                    flag_ovf,
  output logic                    flag_unf,
  output logic                    flag_prec,
  output logic                    rnd_up
);

  localparam int OUT_W = 1 + DBL_EXP_W + DBL_FRAC_W;
  localparam int UNB_W = EXT_EXP_W + 3;
  localparam int NFMT  = 2;

  val_class_e              cls;
  logic signed [UNB_W-1:0] e_unb;

  logic [OUT_W-1:0] f_word [NFMT];
  logic [NFMT-1:0]  f_store, f_inv, f_ovf, f_unf, f_prec, f_up;

  ext_classify #(
    .EXP_W (EXT_EXP_W),
    .SIG_W (EXT_SIG_W),
    .UNB_W (UNB_W)
  ) u_cls (
    .exp_i   (in_exp),
    .sig_i   (in_sig),
    .cls_o   (cls),
    .e_unb_o (e_unb)
  );

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int EW = (g == 0) ? SGL_EXP_W  : DBL_EXP_W;
    localparam int FW = (g == 0) ? SGL_FRAC_W : DBL_FRAC_W;
    narrow_fmt #(
      .EXP_W  (EW),
      .FRAC_W (FW),
      .SIG_W  (EXT_SIG_W),
      .UNB_W  (UNB_W),
      .OUT_W  (OUT_W)
    ) u_nar (
      .sign_i  (in_sign),
      .cls_i   (cls),
      .e_unb_i (e_unb),
      .sig_i   (in_sig),
      .rc_i    (rnd_mode),
      .omask_i (ovf_mask),
      .word_o  (f_word[g]),
      .store_o (f_store[g]),
      .inv_o   (f_inv[g]),
      .ovf_o   (f_ovf[g]),
      .unf_o   (f_unf[g]),
      .prec_o  (f_prec[g]),
      .up_o    (f_up[g])
    );
  end

  logic sel;
  assign sel = dst_dbl;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      store_en  <= 1'b0;
      flag_inv  <= 1'b0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
      flag_prec <= 1'b0;
      rnd_up    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_word  <= f_word[sel];
      store_en  <= in_valid & f_store[sel];
      flag_inv  <= in_valid & f_inv[sel];
      flag_ovf  <= in_valid & f_ovf[sel];
      flag_unf  <= in_valid & f_unf[sel];
      flag_prec <= in_valid & f_prec[sel];
      rnd_up    <= in_valid & f_up[sel];
    end
  end

endmodule

// File: rtl/ext_store_narrow_chk.sv
module ext_store_narrow_chk #(
  parameter int DBL_EXP_W  = 11,
  parameter int DBL_FRAC_W = 52
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic dst_dbl,
  input logic ovf_mask,
  input logic out_valid,
  input logic [DBL_EXP_W+DBL_FRAC_W:0] out_word,
  input logic store_en,
  input logic flag_inv,
  input logic flag_ovf,
  input logic flag_prec,
  input logic rnd_up
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !out_valid && !store_en && !flag_inv && !flag_ovf);

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_latency_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_single_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && !dst_dbl |=> out_word[DBL_EXP_W+DBL_FRAC_W:32] == '0);

  assert_no_overflow_store_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && !ovf_mask |=> !(flag_ovf && store_en) && (store_en || out_word == '0));

  assert_masked_ovf_inexact_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && flag_ovf |-> flag_prec);

  assert_up_needs_prec_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && rnd_up |-> flag_prec);

  assert_inv_gives_nan_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid && dst_dbl |=> !flag_inv ||
      (out_word[DBL_FRAC_W +: DBL_EXP_W] == '1 && out_word[DBL_FRAC_W-1]));

  assert_store_blocked_only_by_ovf_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> store_en || flag_ovf);

endmodule

bind ext_store_narrow ext_store_narrow_chk #(
  .DBL_EXP_W  (DBL_EXP_W),
  .DBL_FRAC_W (DBL_FRAC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .dst_dbl   (dst_dbl),
  .ovf_mask  (ovf_mask),
  .out_valid (out_valid),
  .out_word  (out_word),
  .store_en  (store_en),
  .flag_inv  (flag_inv),
  .flag_ovf  (flag_ovf),
  .flag_prec (flag_prec),
  .rnd_up    (rnd_up)
);

// File: tb/ext_store_narrow_tb.sv
`timescale 1ns/1ps
module ext_store_narrow_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [14:0] in_exp = '0;
  logic [63:0] in_sig = '0;
  logic        dst_dbl = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        ovf_mask = 1'b1;
  logic        out_valid, store_en, flag_inv, flag_ovf, flag_unf, flag_prec, rnd_up;
  logic [63:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_store_narrow u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign), .in_exp(in_exp),
    .in_sig(in_sig), .dst_dbl(dst_dbl), .rnd_mode(rnd_mode), .ovf_mask(ovf_mask),
    .out_valid(out_valid), .out_word(out_word), .store_en(store_en), .flag_inv(flag_inv),
    .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_prec(flag_prec), .rnd_up(rnd_up)
  );

  typedef struct {
    logic [63:0] word;
    logic [5:0]  fl;   // store, inv, ovf, unf, prec, up
    string       tag;
  } exp_t;

  exp_t q[$];

  function automatic logic [63:0] mk(input logic dbl, input logic s, input int ex,
                                     input logic [127:0] fr);
    if (dbl) return {s, ex[10:0], fr[51:0]};
    return {32'd0, s, ex[7:0], fr[22:0]};
  endfunction

  // Behavioural reference: value = m * 2^(E-63), re-quantized at the destination's lsb weight.
  function automatic exp_t model(input string tag, input logic s, input logic [14:0] e,
                                 input logic [63:0] m, input logic dbl, input logic [1:0] rc,
                                 input logic om);
    exp_t r;
    int F = dbl ? 52 : 23;
    int EW = dbl ? 11 : 8;
    int B = dbl ? 1023 : 127;
    int EMAXF = (1 << EW) - 1;
    int E, qe, d, ex;
    logic [127:0] mm, kept, rem, half;
    logic inc, ovf, toinf, unf, prec;
    r.tag = tag; r.fl = 6'b100000; r.word = '0;
    if (e == 15'h7fff) begin
      if (!m[63]) begin
        r.word = mk(dbl, 1'b1, EMAXF, 128'd1 << (F-1)); r.fl = 6'b110000;
      end else if (m[62:0] == 0) begin
        r.word = mk(dbl, s, EMAXF, 128'd0);
      end else begin
        mm = {64'd0, m[62:0]} >> (63 - F);
        if (!m[62]) begin mm = mm | (128'd1 << (F-1)); r.fl = 6'b110000; end
        r.word = mk(dbl, s, EMAXF, mm);
      end
      return r;
    end
    if (e == 0 && m == 0) begin r.word = mk(dbl, s, 0, 128'd0); return r; end
    if (e != 0 && !m[63]) begin
      r.word = mk(dbl, 1'b1, EMAXF, 128'd1 << (F-1)); r.fl = 6'b110000; return r;
    end
    E = (e == 0) ? -16382 : int'(e) - 16383;
    unf = (E < 1 - B);
    qe = unf ? (1 - B - F) : (E - F);
    d = qe - (E - 63);
    if (d > 100) d = 100;
    mm = {64'd0, m};
    kept = mm >> d;
    rem = mm - (kept << d);
    half = 128'd1 << (d - 1);
    case (rc)
      2'b00: inc = (rem > half) || (rem == half && kept[0]);
      2'b01: inc = (rem != 0) && s;
      2'b10: inc = (rem != 0) && !s;
      default: inc = 1'b0;
    endcase
    kept = kept + {127'd0, inc};
    if (kept >= (128'd1 << (F + 1))) begin kept = kept >> 1; qe = qe + 1; end
    ex = (kept >= (128'd1 << F)) ? qe + F + B : 0;
    ovf = (ex >= EMAXF);
    toinf = (rc == 2'b00) || (rc == 2'b10 && !s) || (rc == 2'b01 && s);
    prec = (rem != 0) || ovf;
    if (ovf) r.word = toinf ? mk(dbl, s, EMAXF, 128'd0) : mk(dbl, s, EMAXF - 1, '1);
    else     r.word = mk(dbl, s, ex, kept);
    r.fl = {!(ovf && !om), 1'b0, ovf, unf, prec, ovf ? toinf : inc};
    if (ovf && !om) r.word = '0;
    return r;
  endfunction

  task automatic send(input string tag, input logic s, input logic [14:0] e,
                      input logic [63:0] m, input logic dbl, input logic [1:0] rc,
                      input logic om);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = e; in_sig = m;
    dst_dbl = dbl; rnd_mode = rc; ovf_mask = om;
    q.push_back(model(tag, s, e, m, dbl, rc, om));
  endtask

  // Compare on every falling edge: outputs reflect the input registered one edge earlier.
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      exp_t x;
      logic [5:0] got;
      got = {store_en, flag_inv, flag_ovf, flag_unf, flag_prec, rnd_up};
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2: out_valid=1 actual, no pending input expected");
      end else begin
        x = q.pop_front();
        if (out_word !== x.word || got !== x.fl) begin
          errors++;
          $display("FAIL %s: actual word=%h flags=%b expected word=%h flags=%b",
                   x.tag, out_word, got, x.word, x.fl);
        end
      end
    end
  end

  localparam logic [63:0] ONE  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PI_M = 64'hC90F_DAA2_2168_C235;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 0 || out_word !== 0 || store_en !== 0 || flag_inv !== 0 ||
        flag_ovf !== 0 || flag_unf !== 0 || flag_prec !== 0 || rnd_up !== 0) begin
      errors++;
      $display("FAIL R1: actual valid=%b word=%h store=%b expected all zero", out_valid, out_word, store_en);
    end
    rst = 1'b0;
    // R2/R6: exact values in both formats
    send("R6", 0, 15'd16383, ONE, 0, 2'b00, 1);
    send("R6", 0, 15'd16383, 64'hC000_0000_0000_0000, 1, 2'b00, 1);
    send("R6", 1, 15'd16383 + 15'd100, ONE, 0, 2'b00, 1);
    send("R2", 1, 15'd16383 - 15'd1000, ONE, 1, 2'b00, 1);
    // R5/R8: every mode, both signs, both formats
    for (int rc = 0; rc < 4; rc++) begin
      for (int sg = 0; sg < 2; sg++) begin
        send("R5", sg[0], 15'd16384, PI_M, 0, rc[1:0], 1);
        send("R8", sg[0], 15'd16384, PI_M, 1, rc[1:0], 1);
      end
    end
    // R5: ties to even, single (guard at bit 39) and double (guard at bit 10)
    send("R5", 0, 15'd16383, 64'h8000_0080_0000_0000, 0, 2'b00, 1);
    send("R5", 0, 15'd16383, 64'h8000_0180_0000_0000, 0, 2'b00, 1);
    send("R5", 0, 15'd16383, 64'h8000_0000_0000_0400, 1, 2'b00, 1);
    send("R5", 0, 15'd16383, 64'h8000_0000_0000_0C00, 1, 2'b00, 1);
    // R5: carry out of the significand into the exponent
    send("R5", 0, 15'd16383, ALL1, 0, 2'b10, 1);
    send("R5", 1, 15'd16383, ALL1, 1, 2'b00, 1);
    send("R5", 0, 15'd16383, ALL1, 1, 2'b11, 1);
    // R3/R4: overflow, masked in every mode and sign, then unmasked
    for (int rc = 0; rc < 4; rc++) begin
      send("R4", 0, 15'd16383 + 15'd128, ONE, 0, rc[1:0], 1);
      send("R4", 1, 15'd16383 + 15'd1024, ONE, 1, rc[1:0], 1);
    end
    send("R3", 0, 15'd16383 + 15'd128, ONE, 0, 2'b00, 0);
    send("R3", 1, 15'd16383 + 15'd1024, PI_M, 1, 2'b11, 0);
    send("R3", 0, 15'd16383 + 15'd127, ALL1, 0, 2'b00, 0);
    send("R12", 0, 15'd16383 + 15'd127, ALL1, 0, 2'b11, 0);
    send("R12", 0, 15'd16383 + 15'd1023, ALL1, 1, 2'b11, 0);
    // R7: tiny values, denormal results, rounding into the smallest normal
    send("R7", 0, 15'd16383 - 15'd130, ONE, 0, 2'b00, 1);
    send("R7", 1, 15'd16383 - 15'd130, PI_M, 0, 2'b01, 1);
    send("R7", 0, 15'd16383 - 15'd127, ALL1, 0, 2'b00, 1);
    send("R7", 0, 15'd16383 - 15'd1030, PI_M, 1, 2'b10, 1);
    send("R7", 0, 15'd0, 64'd1, 0, 2'b10, 1);
    send("R7", 0, 15'd0, 64'd1, 1, 2'b11, 1);
    send("R7", 0, 15'd16383 - 15'd200, ONE, 0, 2'b00, 1);
    // R9: zeros and infinities
    send("R9", 0, 15'd0, 64'd0, 0, 2'b10, 0);
    send("R9", 1, 15'd0, 64'd0, 1, 2'b01, 0);
    send("R9", 0, 15'h7fff, ONE, 0, 2'b00, 0);
    send("R9", 1, 15'h7fff, ONE, 1, 2'b00, 0);
    // R10: quiet and signalling NaNs
    send("R10", 0, 15'h7fff, 64'hC000_0000_0000_0001, 0, 2'b00, 1);
    send("R10", 1, 15'h7fff, 64'hE123_4567_89AB_CDEF, 1, 2'b00, 1);
    send("R10", 0, 15'h7fff, 64'h8000_0000_0000_0001, 1, 2'b00, 1);
    send("R10", 1, 15'h7fff, 64'hA5A5_A5A5_A5A5_A5A5, 0, 2'b00, 1);
    // R11: unsupported encodings
    send("R11", 0, 15'd16383, 64'h4000_0000_0000_0000, 0, 2'b00, 1);
    send("R11", 0, 15'h7fff, 64'd0, 1, 2'b00, 1);
    send("R11", 0, 15'h7fff, 64'h7000_0000_0000_0000, 0, 2'b00, 1);
    // Random vectors near both exponent limits
    for (int i = 0; i < 600; i++) begin
      logic dbl;
      int b, off;
      logic [63:0] m;
      dbl = $urandom_range(0, 1) == 1;
      b = dbl ? 1023 : 127;
      off = $urandom_range(0, 3) == 0 ? $urandom_range(0, 2 * b) - b
                                      : ($urandom_range(0, 1) == 1 ? b - 3 + $urandom_range(0, 6)
                                                                   : -b - $urandom_range(0, 60));
      m = {$urandom, $urandom};
      m[63] = 1'b1;
      send("R5", $urandom_range(0, 1) == 1, 15'(16383 + off), m, dbl,
           2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d results missing, expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule